// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

The block is a memory-mapped SPI master with a 32-bit register bus and a 1 KiB decoded window. Software writes a byte to the data register, and the controller shifts it out on SPI mode 0 (clock idles low, sample on the rising edge, MSB first). The byte the slave returns during the same eight clocks goes into an eight-entry receive queue. Each read of the data register takes the oldest entry from that queue.

The SPI clock runs at the bus clock divided by 2^(code+1), where code is a 3-bit field in the first control register. One interrupt line reports buffer events. The interrupt is raised when a transfer finishes and any event or request enable in the second control register is set. Any data-register access drops it, and so does turning the peripheral off. The block also has a 16-bit polynomial register, which is only stored. It has an audio-mode configuration register whose enable bit can never be set.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the status register (offset 0x08) reads 0x2, the polynomial register (0x10) reads 0x0007, control-1 (0x00) and control-2 (0x04) read 0, and `irq` is low.
- R2: Control-1 keeps only bits 2 (master), 5:3 (divider code), 6 (enable), 8 (internal select level) and 9 (software select), so writing all ones reads back 0x37C. Control-2 keeps only bits 7, 6, 1 and 0, so writing all ones reads back 0xC3. The polynomial register keeps 16 bits.
- R3: The audio-mode configuration register (0x1C) always reads 0, including bit 10, whatever is written to it.
- R4: With control-1 bits 2 and 6 both set, a write to the data register (0x0C) drives `spi_cs_n` low and sends the low byte MSB first in eight SCLK periods, in mode 0. The byte sampled from `spi_miso` on the rising edges is then queued.
- R5: The SCLK period is 2^(code+1) bus clocks, where code is control-1 bits 5:3, captured when the transfer starts.
- R6: Status bit 1 (TX empty) reads 0 while a transfer is in progress. A data-register write during a transfer starts nothing and queues nothing.
- R7: A data-register write while control-1 bit 2 or bit 6 is clear produces no SCLK activity and queues the value 0x00.
- R8: The receive queue holds 8 bytes and returns them in arrival order. Status bit 0 (RX not empty) is 1 exactly when the queue holds at least one byte. A byte that arrives when the queue is full is dropped.
- R9: Reading the data register with an empty queue returns 0 and leaves the queue empty.
- R10: When a transfer completes, `irq` goes high if any of control-2 bits 7, 6, 1 or 0 is set, and stays low if none is set.
- R11: Any read or write of the data register deasserts `irq`.
- R12: A control-1 write that clears bit 6 while it was set deasserts `irq` on the next cycle.
- R13: A control-2 write with bit 0 set asserts `irq` on the next cycle.
- R14: A byte-wide access (`bus_byte`=1) at an offset that is a multiple of 4 behaves as a 32-bit access whose data is the zero-extended low byte. A byte write at any other offset has no effect, and a byte read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte-wide access, 0 = 32-bit access |
| bus_addr | input | 10 | Byte offset inside the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while a read is strobed |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low slave select, low for the duration of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- **Queue overflow.** A ninth byte arriving at a full queue must vanish, so the eight earlier bytes are read back in order. A design that overwrote an entry or wrapped a pointer would return a stale byte or the wrong one.
- **Write during a transfer.** A design that started a second transfer would show sixteen SCLK rises and queue two bytes.
- **Transfer without a selected slave.** This must queue 0x00 with no clock activity. A design that shifted anyway would toggle SCLK.
- **Interrupt sources.** Raising on completion, clearing on a data access, clearing when enable drops and re-arming through control-2 bit 0 are each checked on the cycle after their trigger. A wrong priority would leave `irq` at the wrong level.
- **Misaligned byte accesses.** These are checked on both writes and reads. A design that decoded only the word index would corrupt control-2 or start a transfer.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CODE_W = 3;
  localparam int DIV_W  = 2 ** CODE_W;

  // word indices (byte offset / 4)
  localparam logic [7:0] IDX_CTL1 = 8'd0;
  localparam logic [7:0] IDX_CTL2 = 8'd1;
  localparam logic [7:0] IDX_STAT = 8'd2;
  localparam logic [7:0] IDX_DATA = 8'd3;
  localparam logic [7:0] IDX_POLY = 8'd4;
  localparam logic [7:0] IDX_AUD  = 8'd7;

  localparam logic [31:0] CTL1_KEEP = 32'h0000_037C;
  localparam logic [31:0] CTL2_KEEP = 32'h0000_00C3;
  localparam logic [15:0] POLY_INIT = 16'h0007;

  localparam int CTL1_MASTER = 2;
  localparam int CTL1_ON     = 6;
  localparam int CTL2_RXREQ  = 0;

  // number of bus clocks in one half SCLK period
  function automatic logic [DIV_W-1:0] half_cycles(input logic [CODE_W-1:0] code);
    return {{(DIV_W-1){1'b0}}, 1'b1} << code;
  endfunction

  // any buffer event or request enable set in control-2
  function automatic logic irq_wanted(input logic [31:0] ctl2);
    return ctl2[7] | ctl2[6] | ctl2[1] | ctl2[0];
  endfunction
endpackage

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  // R8: an arrival at a full queue changes nothing
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wr_ptr)));

  // R9: a pop of an empty queue leaves it empty
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        tx_byte,
  input  logic [CODE_W-1:0] code,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [7:0]        rx_byte
);
  logic [CODE_W-1:0] code_q;
  logic [DIV_W-1:0]  div_q;
  logic [2:0]        bit_q;
  logic [7:0]        tx_sh, rx_sh;
  logic              busy_q, sclk_q, tick, last_bit;

  assign tick     = busy_q && (div_q == half_cycles(code_q) - 1'b1);
  assign last_bit = (bit_q == 3'd7);
  assign done     = tick && sclk_q && last_bit;
  assign busy     = busy_q;
  assign sclk     = sclk_q;
  assign mosi     = busy_q & tx_sh[7];
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      code_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        code_q <= code;
        tx_sh  <= tx_byte;
      end
    end else if (tick) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R4: SCLK is low whenever a transfer has just ended
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !sclk_q);

  // R4: data out is held across every rising SCLK edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(tx_sh[7]));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_byte,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        irq
);
  logic [31:0] ctl1_q, ctl2_q, word_rd, wval;
  logic [15:0] poly_q;
  logic [7:0]  widx, rx_byte, fifo_dout, push_data;
  logic        acc_ok, wr_ev, rd_ev, data_wr, data_rd, data_acc;
  logic        slave_ready, xfer_start, null_push, xfer_done, busy;
  logic        push, pop, empty, full, en_drop, ctl2_rearm, irq_q;

  // access qualification (R14)
  assign widx     = bus_addr[9:2];
  assign acc_ok   = !bus_byte || (bus_addr[1:0] == 2'b00);
  assign wr_ev    = bus_sel && bus_wr && acc_ok;
  assign rd_ev    = bus_sel && !bus_wr && acc_ok;
  assign wval     = bus_byte ? {24'h0, bus_wdata[7:0]} : bus_wdata;
  assign data_wr  = wr_ev && (widx == IDX_DATA);
  assign data_rd  = rd_ev && (widx == IDX_DATA);
  assign data_acc = data_wr || data_rd;

  // transfer launch
  assign slave_ready = ctl1_q[CTL1_MASTER] && ctl1_q[CTL1_ON];
  assign xfer_start  = data_wr && !busy && slave_ready;
  assign null_push   = data_wr && !busy && !slave_ready;
  assign push        = xfer_done || null_push;
  assign push_data   = xfer_done ? rx_byte : 8'h00;
  assign pop         = data_rd && !empty;

  assign en_drop    = wr_ev && (widx == IDX_CTL1) && ctl1_q[CTL1_ON] && !wval[CTL1_ON];
  assign ctl2_rearm = wr_ev && (widx == IDX_CTL2) && wval[CTL2_RXREQ];

  spi_byte_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (xfer_start),
    .tx_byte (wval[7:0]),
    .code    (ctl1_q[5:3]),
    .miso    (spi_miso),
    .busy    (busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (xfer_done),
    .rx_byte (rx_byte)
  );

  spi_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_data),
    .pop   (pop),
    .dout  (fifo_dout),
    .empty (empty),
    .full  (full)
  );

  assign spi_cs_n = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
      poly_q <= POLY_INIT;
    end else if (wr_ev) begin
      case (widx)
        IDX_CTL1: ctl1_q <= wval & CTL1_KEEP;
        IDX_CTL2: ctl2_q <= wval & CTL2_KEEP;
        IDX_POLY: poly_q <= wval[15:0];
        default:  ;
      endcase
    end
  end

  // interrupt: enable drop wins, then completion, then re-arm, then data access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                irq_q <= 1'b0;
    else if (en_drop)                          irq_q <= 1'b0;
    else if (xfer_done && irq_wanted(ctl2_q))  irq_q <= 1'b1;
    else if (ctl2_rearm)                       irq_q <= 1'b1;
    else if (data_acc)                         irq_q <= 1'b0;
  end
  assign irq = irq_q;

  always_comb begin
    case (widx)
      IDX_CTL1: word_rd = ctl1_q;
      IDX_CTL2: word_rd = ctl2_q;
      IDX_STAT: word_rd = {30'h0, !busy, !empty};
      IDX_DATA: word_rd = empty ? 32'h0 : {24'h0, fifo_dout};
      IDX_POLY: word_rd = {16'h0, poly_q};
      default:  word_rd = 32'h0;
    endcase
    bus_rdata = '0;
    if (rd_ev) bus_rdata = bus_byte ? {24'h0, word_rd[7:0]} : word_rd;
  end

  // R3: audio-mode register never reads back a set bit
  p_aud_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && (widx == IDX_AUD)) |-> (bus_rdata == 32'h0));

  // R10: completion with an enable set raises the line
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && irq_wanted(ctl2_q) && !en_drop) |=> irq);

  // R11: a data access with nothing completing clears the line
  p_data_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !xfer_done) |=> !irq);

  // R12: dropping the enable clears the line
  p_en_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en_drop |=> !irq);

  // R13: control-2 bit 0 write raises the line
  p_rearm_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ctl2_rearm |=> irq);

  // R6: select stays low for the whole transfer
  p_cs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !xfer_done) |=> !spi_cs_n);
endmodule

// File: tb/tb_spi_reg_master.sv
`timescale 1ns/1ps
module tb_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, irq;

  int tests = 0, fails = 0;
  logic [7:0] slv_tx = 8'h00, slv_sh = 8'h00, slv_rx = 8'h00;
  int  rise_cnt = 0, cs_falls = 0;
  time t_prev = 0, t_last = 0;

  always #5 clk = ~clk;

  spi_reg_master dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
  );

  // mode-0 slave model
  assign spi_miso = slv_sh[7];
  always @(negedge spi_cs_n) begin slv_sh = slv_tx; cs_falls++; end
  always @(negedge spi_sclk) if (!spi_cs_n) slv_sh = {slv_sh[6:0], 1'b0};
  always @(posedge spi_sclk) begin
    slv_rx = {slv_rx[6:0], spi_mosi};
    rise_cnt++;
    t_prev = t_last;
    t_last = $time;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic b = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_byte = b; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, input logic b = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_byte = b; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(10'h08, s);
      if (s[1]) return;
    end
    chk("R6 idle timeout", 32'h0, 32'h1);
  endtask

  task automatic drain();
    logic [31:0] s, d;
    for (int i = 0; i < 20; i++) begin
      rd(10'h08, s);
      if (!s[0]) return;
      rd(10'h0C, d);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h08, d); chk("R1 status", d, 32'h2);
    rd(10'h10, d); chk("R1 poly", d, 32'h7);
    rd(10'h00, d); chk("R1 ctl1", d, 32'h0);
    rd(10'h04, d); chk("R1 ctl2", d, 32'h0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(10'h00, 32'hFFFF_FFFF); rd(10'h00, d); chk("R2 ctl1 mask", d, 32'h37C);
    wr(10'h00, 32'h0);
    wr(10'h04, 32'hFFFF_FFFF); rd(10'h04, d); chk("R2 ctl2 mask", d, 32'hC3);
    wr(10'h04, 32'h0);
    rd(10'h0C, d); chk("R11 irq after empty read", irq, 1'b0);
    wr(10'h10, 32'hFFFF_ABCD); rd(10'h10, d); chk("R2 poly", d, 32'hABCD);
    wr(10'h1C, 32'hFFFF_FFFF); rd(10'h1C, d); chk("R3 audio reg", d, 32'h0);
  endtask

  task automatic t_xfer();
    logic [31:0] d;
    int r0, c0;
    wr(10'h00, 32'h44);               // master+enable, code 0
    slv_tx = 8'h3C; r0 = rise_cnt; c0 = cs_falls;
    wr(10'h0C, 32'hFFFF_FFA5);
    wait_idle();
    chk("R4 mosi byte", slv_rx, 8'hA5);
    chk("R4 eight clocks", rise_cnt - r0, 8);
    chk("R4 select asserted", cs_falls - c0, 1);
    rd(10'h08, d); chk("R8 rx not empty", d, 32'h3);
    rd(10'h0C, d); chk("R4 rx byte", d, 32'h3C);
    chk("R5 period code0", 32'(t_last - t_prev), 32'd20);
  endtask

  task automatic t_baud();
    logic [31:0] d;
    wr(10'h00, 32'h44 | (2 << 3));    // code 2
    slv_tx = 8'h81;
    wr(10'h0C, 32'h5E); wait_idle();
    chk("R5 period code2", 32'(t_last - t_prev), 32'd80);
    rd(10'h0C, d); chk("R4 rx code2", d, 32'h81);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int r0;
    wr(10'h00, 32'h44 | (3 << 3));    // code 3: 128 cycles
    slv_tx = 8'hC7; r0 = rise_cnt;
    wr(10'h0C, 32'h96);
    rd(10'h08, d); chk("R6 txe low while busy", d[1], 1'b0);
    wr(10'h0C, 32'h11);
    wait_idle();
    chk("R6 busy write ignored clocks", rise_cnt - r0, 8);
    chk("R6 busy write ignored data", slv_rx, 8'h96);
    rd(10'h0C, d); chk("R6 one byte queued", d, 32'hC7);
    rd(10'h08, d); chk("R6 queue empty after", d, 32'h2);
  endtask

  task automatic t_noslave();
    logic [31:0] d;
    int r0, c0;
    wr(10'h00, 32'h04);               // master, not enabled
    r0 = rise_cnt; c0 = cs_falls;
    wr(10'h0C, 32'h77);
    rd(10'h08, d); chk("R7 zero queued", d, 32'h3);
    chk("R7 no clocks", rise_cnt - r0, 0);
    chk("R7 no select", cs_falls - c0, 0);
    rd(10'h0C, d); chk("R7 zero value", d, 32'h0);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    drain();
    wr(10'h00, 32'h44);
    for (int i = 0; i < 9; i++) begin
      slv_tx = (i == 8) ? 8'h5A : 8'hA0 + 8'(i);
      wr(10'h0C, 32'h00); wait_idle();
    end
    rd(10'h08, d); chk("R8 full reads not empty", d, 32'h3);
    for (int i = 0; i < 8; i++) begin
      rd(10'h0C, d); chk("R8 order", d, 32'hA0 + 32'(i));
    end
    rd(10'h08, d); chk("R8 ninth dropped", d, 32'h2);
    rd(10'h0C, d); chk("R9 empty read zero", d, 32'h0);
    rd(10'h08, d); chk("R9 still empty", d, 32'h2);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    drain();
    wr(10'h00, 32'h44); wr(10'h04, 32'h0);
    rd(10'h0C, d);
    wr(10'h0C, 32'h12); wait_idle();
    chk("R10 no enable no irq", irq, 1'b0);
    wr(10'h04, 32'h80);
    wr(10'h0C, 32'h34); wait_idle();
    chk("R10 tx-empty enable irq", irq, 1'b1);
    rd(10'h0C, d);
    chk("R11 read clears irq", irq, 1'b0);
    wr(10'h04, 32'h40);
    wr(10'h0C, 32'h56); wait_idle();
    chk("R10 rx enable irq", irq, 1'b1);
    wr(10'h0C, 32'h56); wait_idle();  // write clears, completion sets again
    wr(10'h00, 32'h04);
    chk("R12 enable drop clears", irq, 1'b0);
    wr(10'h04, 32'h01);
    chk("R13 rearm sets", irq, 1'b1);
    wr(10'h0C, 32'h00);
    chk("R11 write clears irq", irq, 1'b0);
    drain();
  endtask

  task automatic t_byte();
    logic [31:0] d;
    wr(10'h04, 32'h0);
    wr(10'h05, 32'hC3, 1'b1);
    rd(10'h04, d); chk("R14 misaligned write ignored", d, 32'h0);
    wr(10'h04, 32'hFFFF_FF41, 1'b1);
    rd(10'h04, d); chk("R14 aligned byte zero-extended", d, 32'h41);
    rd(10'h05, d, 1'b1); chk("R14 misaligned read zero", d, 32'h0);
    wr(10'h00, 32'h344);
    rd(10'h00, d, 1'b1); chk("R14 aligned byte read", d, 32'h44);
    wr(10'h0D, 32'h99, 1'b1);
    rd(10'h08, d); chk("R14 misaligned data write no push", d, 32'h2);
    wr(10'h04, 32'h0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_xfer();
    t_baud();
    t_busy();
    t_noslave();
    t_fifo();
    t_irq();
    t_byte();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule